// File: doc/BRIEF.md
# Run-Time Configurable Two-Level AND/OR Logic Array

This block is a sum-of-products logic array whose connections are written at run time through a small synchronous configuration port. The first level is an AND plane: each product term holds one two-bit code per primary input, which says whether that input must be high, must be low, is ignored, or blocks the term. The second level is an OR plane: each output holds one connect bit per product term. Every output is the OR of the product terms connected to it, and it is computed combinationally from the primary input vector and the stored configuration.

A mode input selects one of two topologies. In the shared topology any output may use any product term, so one term can drive several outputs. In the grouped topology each output owns a fixed, non-overlapping block of consecutive terms, and connect bits outside that block are ignored. The configuration can be read back through the same port. A registered copy of the outputs is provided next to the combinational ones. Widths and counts are parameters, with defaults of 16 inputs, 48 terms, 8 outputs and 4 terms per output group.

Top module: `sop_array`

## Requirements
- R1: AND-plane row t holds, for input i, a code at bits [2i+1:2i]. Code 2'b10 requires the input to be 1, 2'b01 requires it to be 0, 2'b00 removes the input from the term, and 2'b11 forces the term to 0 whatever the inputs are.
- R2: A product term whose codes are all 2'b00 evaluates to 1. It changes an output only when that output connects it.
- R3: In OR-plane row o, bit t connects term t to output o. Output o (bit o of `f_comb`) is the OR of its connected terms and is 0 when none of them is true.
- R4: When `mode_grouped` = 0, any term can feed any number of outputs at the same time.
- R5: When `mode_grouped` = 1, output o uses only terms o*GRP_TERMS through o*GRP_TERMS+GRP_TERMS-1. Connect bits outside that range have no effect.
- R6: After reset, every AND-plane code is 2'b11, every OR-plane bit is 0, and both output vectors are 0.
- R7: A write takes place on a rising clock edge with `cfg_we` = 1. It stores `cfg_wdata` (low bits) into row `cfg_row` of the plane chosen by `cfg_plane` (0 = AND plane, 1 = OR plane). The new contents drive the outputs from that edge on. Nothing is stored while `cfg_we` = 0.
- R8: `cfg_rdata` shows, combinationally, the row selected by `cfg_plane` and `cfg_row`, zero-extended. Rows that do not exist read as 0.
- R9: `f_reg` equals the value `f_comb` had at the previous rising edge.
- R10: A write to a row index at or above that plane's row count (N_TERM for the AND plane, N_OUT for the OR plane) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_plane | input | 1 | Plane select: 0 = AND plane, 1 = OR plane |
| cfg_row | input | ROW_W | Row index for write and readback |
| cfg_wdata | input | CFG_W | Row data to write |
| cfg_rdata | output | CFG_W | Readback of the selected row |
| mode_grouped | input | 1 | 0 = shared terms, 1 = fixed term groups per output |
| in_vec | input | N_IN | Primary inputs |
| f_comb | output | N_OUT | Combinational outputs |
| f_reg | output | N_OUT | Outputs registered once |

## Verification
The bench changes `in_vec` and `mode_grouped` on the falling edge and reads `f_comb` and `cfg_rdata` 1 ns later in the same cycle, because neither has a register on its path. A configuration write is held across one rising edge. Its effect is checked after that edge, because the planes update there. `f_reg` is checked 1 ns after the rising edge that follows each input change, which is the single register stage on its path. All 16 input patterns are swept for every configuration and mode. The expected outputs are computed from a model of the written rows that the bench keeps for itself.

// File: rtl/sop_pkg.sv
package sop_pkg;

    localparam logic PLANE_AND = 1'b0;
    localparam logic PLANE_OR  = 1'b1;

    localparam logic [1:0] CODE_SKIP  = 2'b00;
    localparam logic [1:0] CODE_LOW   = 2'b01;
    localparam logic [1:0] CODE_HIGH  = 2'b10;
    localparam logic [1:0] CODE_BLOCK = 2'b11;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sop_and_plane.sv
module sop_and_plane
    import sop_pkg::*;
#(
    parameter int N_IN   = 16,
    parameter int N_TERM = 48,
    parameter int ROW_W  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ROW_W-1:0]      row,
    input  logic [2*N_IN-1:0]     wr_data,
    output logic [2*N_IN-1:0]     rd_data,
    input  logic [N_IN-1:0]       in_vec,
    output logic [N_TERM-1:0]     terms
);

    localparam int          CW      = 2 * N_IN;
    localparam logic [ROW_W:0] ROW_LIM = N_TERM[ROW_W:0];

    typedef struct packed {
        logic [N_TERM-1:0][CW-1:0] codes;
    } and_state_t;

    and_state_t st_d, st_q;
    logic       row_ok;

    assign row_ok = ({1'b0, row} < ROW_LIM);

    always_comb begin
        st_d = st_q;
        if (wr_en && row_ok) begin
            st_d.codes[row] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.codes <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (row_ok) begin
            rd_data = st_q.codes[row];
        end
    end

    always_comb begin
        for (int t = 0; t < N_TERM; t++) begin
            logic hit;
            hit = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                unique case (st_q.codes[t][2*i +: 2])
                    CODE_HIGH:  hit = hit & in_vec[i];
                    CODE_LOW:   hit = hit & ~in_vec[i];
                    CODE_SKIP:  hit = hit;
                    default:    hit = 1'b0;
                endcase
            end
            terms[t] = hit;
        end
    end

    AST_AND_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && row_ok) |=> (st_q.codes[$past(row)] == $past(wr_data))); // R7

    AST_AND_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(st_q.codes)); // R7

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
    import sop_pkg::*;
#(
    parameter int N_TERM    = 48,
    parameter int N_OUT     = 8,
    parameter int GRP_TERMS = 4,
    parameter int ROW_W     = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ROW_W-1:0]      row,
    input  logic [N_TERM-1:0]     wr_data,
    output logic [N_TERM-1:0]     rd_data,
    input  logic                  mode_grouped,
    input  logic [N_TERM-1:0]     terms,
    output logic [N_OUT-1:0]      f
);

    localparam logic [ROW_W:0] ROW_LIM = N_OUT[ROW_W:0];

    typedef logic [N_OUT-1:0][N_TERM-1:0] mask_t;

    function automatic mask_t build_group_mask();
        mask_t m;
        m = '0;
        for (int o = 0; o < N_OUT; o++) begin
            for (int t = 0; t < N_TERM; t++) begin
                if ((t / GRP_TERMS) == o) m[o][t] = 1'b1;
            end
        end
        return m;
    endfunction

    localparam mask_t GROUP_MASK = build_group_mask();

    typedef struct packed {
        logic [N_OUT-1:0][N_TERM-1:0] conn;
    } or_state_t;

    or_state_t st_d, st_q;
    logic      row_ok;

    assign row_ok = ({1'b0, row} < ROW_LIM);

    always_comb begin
        st_d = st_q;
        if (wr_en && row_ok) begin
            st_d.conn[row] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.conn <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (row_ok) begin
            rd_data = st_q.conn[row];
        end
    end

    generate
        for (genvar o = 0; o < N_OUT; o++) begin : g_out
            logic [N_TERM-1:0] reach;
            assign reach = mode_grouped ? (st_q.conn[o] & GROUP_MASK[o]) : st_q.conn[o];
            assign f[o]  = |(reach & terms);

            AST_GROUP_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_grouped && ((st_q.conn[o] & GROUP_MASK[o]) == '0)) |-> !f[o]); // R5
        end
    endgenerate

    AST_OR_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(st_q.conn)); // R7

endmodule

// File: rtl/sop_array.sv
module sop_array
    import sop_pkg::*;
#(
    parameter int N_IN      = 16,
    parameter int N_TERM    = 48,
    parameter int N_OUT     = 8,
    parameter int GRP_TERMS = 4,
    parameter int ROW_W     = $clog2(imax(N_TERM, N_OUT)),
    parameter int CFG_W     = imax(2 * N_IN, N_TERM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_plane,
    input  logic [ROW_W-1:0]  cfg_row,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              mode_grouped,
    input  logic [N_IN-1:0]   in_vec,
    output logic [N_OUT-1:0]  f_comb,
    output logic [N_OUT-1:0]  f_reg
);

    localparam int CW = 2 * N_IN;

    logic [N_TERM-1:0] terms;
    logic [CW-1:0]     and_rd;
    logic [N_TERM-1:0] or_rd;
    logic              and_we, or_we;

    assign and_we = cfg_we && (cfg_plane == PLANE_AND);
    assign or_we  = cfg_we && (cfg_plane == PLANE_OR);

    sop_and_plane #(
        .N_IN   (N_IN),
        .N_TERM (N_TERM),
        .ROW_W  (ROW_W)
    ) u_and (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (and_we),
        .row     (cfg_row),
        .wr_data (cfg_wdata[CW-1:0]),
        .rd_data (and_rd),
        .in_vec  (in_vec),
        .terms   (terms)
    );

    sop_or_plane #(
        .N_TERM    (N_TERM),
        .N_OUT     (N_OUT),
        .GRP_TERMS (GRP_TERMS),
        .ROW_W     (ROW_W)
    ) u_or (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (or_we),
        .row          (cfg_row),
        .wr_data      (cfg_wdata[N_TERM-1:0]),
        .rd_data      (or_rd),
        .mode_grouped (mode_grouped),
        .terms        (terms),
        .f            (f_comb)
    );

    always_comb begin
        cfg_rdata = '0;
        if (cfg_plane == PLANE_OR) cfg_rdata[N_TERM-1:0] = or_rd;
        else                       cfg_rdata[CW-1:0]     = and_rd;
    end

    typedef struct packed {
        logic [N_OUT-1:0] f;
    } out_state_t;

    out_state_t out_d, out_q;

    always_comb begin
        out_d   = out_q;
        out_d.f = f_comb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign f_reg = out_q.f;

    AST_REG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        f_reg == $past(f_comb)); // R9

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (f_comb == '0)); // R6

endmodule

// File: tb/sop_array_bench.sv
module sop_array_bench;

    localparam int NI = 4;
    localparam int NT = 8;
    localparam int NO = 2;
    localparam int GT = 4;
    localparam int RW = 3;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_plane = 1'b0;
    logic [RW-1:0] cfg_row = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [CW-1:0] cfg_rdata;
    logic          mode_grouped = 1'b0;
    logic [NI-1:0] in_vec = '0;
    logic [NO-1:0] f_comb, f_reg;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] m_and [NT];
    logic [7:0] m_or  [8];

    always #4 clk = ~clk;

    sop_array #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO), .GRP_TERMS(GT)) u_sop_array (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_plane(cfg_plane),
        .cfg_row(cfg_row), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mode_grouped(mode_grouped), .in_vec(in_vec), .f_comb(f_comb), .f_reg(f_reg)
    );

    function automatic logic term_val(input int t, input logic [NI-1:0] x);
        logic ok = 1'b1;
        for (int i = 0; i < NI; i++) begin
            case (m_and[t][2*i +: 2])
                2'b10: ok = ok & x[i];
                2'b01: ok = ok & ~x[i];
                2'b00: ok = ok;
                default: ok = 1'b0;
            endcase
        end
        return ok;
    endfunction

    function automatic logic [NO-1:0] expect_f(input logic [NI-1:0] x, input logic md);
        logic [NO-1:0] r = '0;
        for (int o = 0; o < NO; o++)
            for (int t = 0; t < NT; t++)
                if (m_or[o][t] && (!md || (t / GT) == o) && term_val(t, x)) r[o] = 1'b1;
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic pl, input int row, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_plane = pl; cfg_row = row[RW-1:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!pl && row < NT) m_and[row] = d;
        if (pl && row < NO)  m_or[row]  = d;
    endtask

    task automatic check_readback(input string tag);
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            cfg_plane = 1'b0; cfg_row = r[RW-1:0];
            #1 check(tag, cfg_rdata, m_and[r]);
            cfg_plane = 1'b1;
            #1 check(tag, cfg_rdata, (r < NO) ? m_or[r] : 8'h00);
        end
    endtask

    task automatic sweep(input string tag, input logic md);
        for (int x = 0; x < 16; x++) begin
            logic [NO-1:0] e;
            @(negedge clk);
            mode_grouped = md;
            in_vec = x[NI-1:0];
            e = expect_f(x[NI-1:0], md);
            #1 check(tag, f_comb, e);
            @(posedge clk);
            #1 check({tag, "/R9"}, f_reg, e);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NT; t++) m_and[t] = 8'hFF;
        for (int o = 0; o < 8; o++)  m_or[o]  = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R6: reset personality and outputs
        check("R6", f_comb, 0);
        check("R6", f_reg, 0);
        check_readback("R6/R8");
        sweep("R6", 1'b0);

        // R1, R3: term0 = in0 & ~in1 on output 0
        cfg_write(1'b0, 0, 8'h06);
        cfg_write(1'b1, 0, 8'h01);
        sweep("R1/R3", 1'b0);

        // R2: constant-one term not yet connected, then connected
        cfg_write(1'b0, 1, 8'h00);
        sweep("R2", 1'b0);
        cfg_write(1'b1, 1, 8'h02);
        sweep("R2", 1'b0);

        // R1: code 11 on input3 blocks term2 even with others skipped
        cfg_write(1'b0, 2, 8'hC0);
        cfg_write(1'b1, 0, 8'h05);
        sweep("R1", 1'b0);

        // R4, R5: term3 shared, term4 outside group of output 0
        cfg_write(1'b0, 3, 8'hA0);
        cfg_write(1'b0, 4, 8'h02);
        cfg_write(1'b1, 0, 8'h19);
        cfg_write(1'b1, 1, 8'h18);
        sweep("R4", 1'b0);
        sweep("R5", 1'b1);
        cfg_write(1'b0, 7, 8'h09);
        cfg_write(1'b1, 1, 8'h88);
        sweep("R4", 1'b0);
        sweep("R5", 1'b1);
        check_readback("R8");

        // R7: no write without enable
        @(negedge clk);
        cfg_we = 1'b0; cfg_plane = 1'b0; cfg_row = 3'd3; cfg_wdata = 8'h55;
        @(negedge clk);
        cfg_plane = 1'b1; cfg_row = 3'd0; cfg_wdata = 8'hFF;
        @(negedge clk);
        check_readback("R7");
        sweep("R7", 1'b0);

        // R10: out-of-range OR row write ignored
        cfg_write(1'b1, 5, 8'hFF);
        cfg_write(1'b1, 2, 8'hFF);
        check_readback("R10");
        sweep("R10", 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule